// File: doc/BRIEF.md
# Command-Driven Byte Serializer with Peripheral Strobes

The block takes bytes from a CPU write port and holds them in an internal first-in first-out store of up to 63 entries. A select line, sampled with each write, marks the byte as either payload, which is queued, or a command, which is decoded at once. Writing stored bytes does not start any serial activity. A start command drains the whole store onto a serial data line. A serial clock runs at half the system clock rate while the drain is in progress.

Once the last bit of the last queued byte has been shifted, an active-low interrupt request goes low. It stays low until software clears it. Two further outputs, an active-low output enable and a latch strobe, are set or cleared by their own commands. With these outputs the block can load and show data in an external shift-register peripheral, such as a serial-in latch driver.

Top module: `sbuf_top`

## Requirements
- R1: While `rst_n` is low, the block forces `irq_n`=1, `oe_n`=1, `latch`=0, `sclk`=0 and `sdata`=0, and it empties the store, so a later start command produces no serial clock.
- R2: A write is a rising `clk` edge with `cs_n`=0 and `wr_n`=0. When `cmd_sel`=0 the byte on `din` is queued. The store keeps at most 63 bytes, and a data write made while it is full is dropped.
- R3: Queuing bytes causes no serial activity. `sclk` stays low until a start command (code 0x01) is written with `cmd_sel`=1.
- R4: Each byte is sent most significant bit first. `sdata` changes only on the falling edge of `sclk` and is stable while `sclk` is high. `sclk` is high for one `clk` cycle and low for at least one, so each bit takes two cycles.
- R5: Queued bytes leave in write order with no gap between them. A drain of N bytes produces exactly 8·N rising `sclk` edges.
- R6: Take the edge that accepts the start command as edge 0. After a drain of N bytes, `irq_n` goes low after edge 16·N and not before. It then stays low while no clear command is written.
- R7: Command 0x06 returns `irq_n` to 1 on the following edge.
- R8: Command 0x03 sets `latch` to 1 and 0x02 sets it to 0. Command 0x05 drives `oe_n` to 0 and 0x04 drives it to 1.
- R9: Command codes other than 0x01 to 0x06 change no output, and any write with `cs_n`=1 is ignored.
- R10: Data writes accepted while a drain is in progress are dropped.
- R11: A start command has no effect while a drain is running or while the store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, one write per clock it is low |
| cmd_sel | input | 1 | 1 = byte is a command, 0 = byte is data |
| din | input | 8 | Write data / command code |
| sdata | output | 1 | Serial data out |
| sclk | output | 1 | Serial clock out |
| oe_n | output | 1 | Active-low output enable to peripheral |
| latch | output | 1 | Latch strobe to peripheral |
| irq_n | output | 1 | Active-low interrupt request, drain complete |

## Verification
The bench fills the store with 64 writes and counts the bits that come out. A design that wrapped its pointers badly or accepted the 64th byte would emit more or fewer than 504 bits, or would emit the wrong bytes. The bench also checks the exact cycle in which the interrupt falls. An off-by-one in the bit counter, or a one-cycle gap between bytes, would move that edge. Data and start writes made during a drain, and a start made after it, expose a design that queues during a transfer or restarts on an empty store, because stray serial clocks appear. The bench also sends unknown codes, writes with chip select high, and resets in the middle of a transfer, to catch outputs that move when they should hold.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   localparam int CODE_W = 8;

   typedef enum logic [CODE_W-1:0] {
      OP_START     = 8'h01,
      OP_LATCH_LO  = 8'h02,
      OP_LATCH_HI  = 8'h03,
      OP_OE_OFF    = 8'h04,
      OP_OE_ON     = 8'h05,
      OP_IRQ_CLR   = 8'h06
   } op_code_e;

   typedef struct packed {
      logic start;
      logic latch_lo;
      logic latch_hi;
      logic oe_off;
      logic oe_on;
      logic irq_clr;
   } op_strobe_t;

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 63,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic              do_push;
   logic              do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = store[rd_ptr];

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == LAST_IDX) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sbuf_cmd_decode.sv
module sbuf_cmd_decode
   import sbuf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] code,
   output op_strobe_t        strobe
);

   logic [CODE_W-1:0] low_code;
   logic              upper_zero;

   generate
      if (DATA_W > CODE_W) begin : g_wide
         assign upper_zero = (code[DATA_W-1:CODE_W] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign low_code = code[CODE_W-1:0];

   always_comb begin
      strobe = '0;
      if (cmd_wr && upper_zero) begin
         case (low_code)
            OP_START:    strobe.start    = 1'b1;
            OP_LATCH_LO: strobe.latch_lo = 1'b1;
            OP_LATCH_HI: strobe.latch_hi = 1'b1;
            OP_OE_OFF:   strobe.oe_off   = 1'b1;
            OP_OE_ON:    strobe.oe_on    = 1'b1;
            OP_IRQ_CLR:  strobe.irq_clr  = 1'b1;
            default:     strobe          = '0;
         endcase
      end
   end

endmodule

// File: rtl/sbuf_serializer.sv
module sbuf_serializer #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              src_empty,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_pop,
   output logic              done,
   output logic              busy,
   output logic              sdata,
   output logic              sclk
);

   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_next;
   logic [BIT_W-1:0]  bits_left;
   logic              launch;
   logic              byte_end;
   logic              out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_next = {shreg[DATA_W-2:0], 1'b0};
         assign out_bit    = shreg[DATA_W-1];
      end else begin : g_lsb
         assign shreg_next = {1'b0, shreg[DATA_W-1:1]};
         assign out_bit    = shreg[0];
      end
   endgenerate

   assign launch   = !busy && start && !src_empty;
   assign byte_end = busy && sclk && (bits_left == '0);
   assign src_pop  = launch || (byte_end && !src_empty);
   assign done     = byte_end && src_empty;
   assign sdata    = busy && out_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sclk      <= 1'b0;
         shreg     <= '0;
         bits_left <= '0;
      end else if (!busy) begin
         sclk <= 1'b0;
         if (launch) begin
            busy      <= 1'b1;
            shreg     <= src_data;
            bits_left <= TOP_BIT;
         end
      end else if (!sclk) begin
         sclk <= 1'b1;
      end else begin
         sclk <= 1'b0;
         if (bits_left != '0) begin
            shreg     <= shreg_next;
            bits_left <= bits_left - 1'b1;
         end else if (!src_empty) begin
            shreg     <= src_data;
            bits_left <= TOP_BIT;
         end else begin
            busy  <= 1'b0;
            shreg <= '0;
         end
      end
   end

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
   import sbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 63,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              cmd_sel,
   input  logic [DATA_W-1:0] din,
   output logic              sdata,
   output logic              sclk,
   output logic              oe_n,
   output logic              latch,
   output logic              irq_n
);

   generate
      if (DATA_W < CODE_W) begin : g_bad_width
         $error("sbuf_top: DATA_W must be at least the command code width");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sbuf_top: DEPTH must be at least 2");
      end
   endgenerate

   logic              wr_hit;
   logic              data_wr;
   logic              cmd_wr;
   logic              xfer_busy;
   logic              xfer_done;
   logic              fifo_pop;
   logic              fifo_empty;
   logic              fifo_full;
   logic [DATA_W-1:0] fifo_head;
   logic [CNT_W-1:0]  fifo_count;
   logic              irq_q;
   op_strobe_t        op;

   assign wr_hit  = !cs_n && !wr_n;
   assign data_wr = wr_hit && !cmd_sel && !xfer_busy;
   assign cmd_wr  = wr_hit && cmd_sel;

   sbuf_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (data_wr),
      .wdata (din),
      .pop   (fifo_pop),
      .rdata (fifo_head),
      .empty (fifo_empty),
      .full  (fifo_full),
      .count (fifo_count)
   );

   sbuf_cmd_decode #(
      .DATA_W (DATA_W)
   ) u_dec (
      .cmd_wr (cmd_wr),
      .code   (din),
      .strobe (op)
   );

   sbuf_serializer #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (op.start),
      .src_empty (fifo_empty),
      .src_data  (fifo_head),
      .src_pop   (fifo_pop),
      .done      (xfer_done),
      .busy      (xfer_busy),
      .sdata     (sdata),
      .sclk      (sclk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_n  <= 1'b1;
         latch <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (op.latch_hi)      latch <= 1'b1;
         else if (op.latch_lo) latch <= 1'b0;
         if (op.oe_on)         oe_n  <= 1'b0;
         else if (op.oe_off)   oe_n  <= 1'b1;
         if (xfer_done)        irq_q <= 1'b1;
         else if (op.irq_clr)  irq_q <= 1'b0;
      end
   end

   assign irq_n = !irq_q;

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 63,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              wr_n,
   input logic              cmd_sel,
   input logic [DATA_W-1:0] din,
   input logic              sdata,
   input logic              sclk,
   input logic              oe_n,
   input logic              latch,
   input logic              irq_n,
   input logic              xfer_busy,
   input logic [CNT_W-1:0]  fifo_count
);

   logic cmd_w;
   assign cmd_w = !cs_n && !wr_n && cmd_sel;

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH));

   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_busy |-> !sclk);

   p_sclk_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |=> !sclk);

   p_sdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));

   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !(cmd_w && din == DATA_W'(8'h06))) |=> !irq_n);

   p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && din == DATA_W'(8'h06) && !xfer_busy) |=> irq_n);

   p_latch_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && din == DATA_W'(8'h03)) |=> latch);

   p_latch_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && din == DATA_W'(8'h02)) |=> !latch);

   p_oe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && din == DATA_W'(8'h05)) |=> !oe_n);

   p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && din == DATA_W'(8'h04)) |=> oe_n);

   p_latch_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_w && (din == DATA_W'(8'h02) || din == DATA_W'(8'h03))) |=> $stable(latch));

   p_no_fill_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_busy |=> fifo_count <= $past(fifo_count));

endmodule

bind sbuf_top sbuf_checker #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .wr_n       (wr_n),
   .cmd_sel    (cmd_sel),
   .din        (din),
   .sdata      (sdata),
   .sclk       (sclk),
   .oe_n       (oe_n),
   .latch      (latch),
   .irq_n      (irq_n),
   .xfer_busy  (xfer_busy),
   .fifo_count (fifo_count)
);

// File: tb/sbuf_top_bench.sv
module sbuf_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;
   // each entry: {command code, expected oe_n, expected latch}
   localparam logic [9:0] VEC [NVEC] = '{
      {8'h03, 1'b1, 1'b1},
      {8'h05, 1'b0, 1'b1},
      {8'h07, 1'b0, 1'b1},
      {8'h02, 1'b0, 1'b0},
      {8'hFF, 1'b0, 1'b0},
      {8'h04, 1'b1, 1'b0},
      {8'h05, 1'b0, 1'b0},
      {8'h00, 1'b0, 1'b0},
      {8'h03, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       cmd_sel = 1'b0;
   logic [7:0] din = '0;
   logic       sdata, sclk, oe_n, latch, irq_n;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic cap [2048];
   int  cap_n = 0;
   logic sclk_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbuf_top u_sbuf_top (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .wr_n (wr_n),
      .cmd_sel (cmd_sel), .din (din), .sdata (sdata), .sclk (sclk),
      .oe_n (oe_n), .latch (latch), .irq_n (irq_n)
   );

   always @(negedge clk) begin
      if (sclk && !sclk_prev && cap_n < 2048) begin
         cap[cap_n] = sdata;
         cap_n = cap_n + 1;
      end
      sclk_prev = sclk;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic [7:0] d, input logic csn = 1'b0);
      cs_n = csn; wr_n = 1'b0; cmd_sel = c; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; cmd_sel = 1'b0; din = '0;
   endtask

   function automatic int byte_at(input int base, input int idx);
      int v = 0;
      for (int k = 0; k < 8; k++) v = (v << 1) | int'(cap[base + 8*idx + k]);
      return v;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      int base;
      int bad;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq_n", irq_n, 1);
      check("R1 oe_n", oe_n, 1);
      check("R1 latch", latch, 0);
      check("R1 sclk", sclk, 0);
      check("R1 sdata", sdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 / R9 command vector walk
      for (int i = 0; i < NVEC; i++) begin
         wr(1'b1, VEC[i][9:2]);
         check($sformatf("R8/R9 vec%0d oe_n", i), oe_n, VEC[i][1]);
         check($sformatf("R8/R9 vec%0d latch", i), latch, VEC[i][0]);
      end

      // R3 no serial activity before start
      wr(1'b0, 8'hA5);
      wr(1'b0, 8'h3C);
      repeat (20) @(negedge clk);
      check("R3 no sclk before start", cap_n, 0);
      base = cap_n;
      wr(1'b1, 8'h01);                      // edge 0
      check("R4 first bit msb", sdata, 1);
      check("R4 sclk low after start", sclk, 0);
      @(negedge clk);                       // edge 1
      check("R4 sclk high", sclk, 1);
      repeat (30) @(negedge clk);           // edge 31
      check("R6 irq not early", irq_n, 1);
      @(negedge clk);                       // edge 32
      check("R6 irq after 16N", irq_n, 0);
      repeat (3) @(negedge clk);
      check("R5 bit count", cap_n - base, 16);
      check("R4 byte0", byte_at(base, 0), 8'hA5);
      check("R5 byte1 order", byte_at(base, 1), 8'h3C);
      repeat (10) @(negedge clk);
      check("R6 irq held", irq_n, 0);
      wr(1'b1, 8'h06);
      check("R7 irq cleared", irq_n, 1);

      // R10 / R11 writes during a drain
      wr(1'b0, 8'h11);
      base = cap_n;
      wr(1'b1, 8'h01);                      // edge 0
      wr(1'b0, 8'hAA);                      // edge 1, dropped
      wr(1'b1, 8'h01);                      // edge 2, ignored
      repeat (13) @(negedge clk);           // edge 15
      check("R11 irq not early", irq_n, 1);
      @(negedge clk);                       // edge 16
      check("R11 irq at 16", irq_n, 0);
      repeat (3) @(negedge clk);
      check("R11 one byte only", cap_n - base, 8);
      check("R11 byte value", byte_at(base, 0), 8'h11);
      wr(1'b1, 8'h06);
      base = cap_n;
      wr(1'b1, 8'h01);
      repeat (20) @(negedge clk);
      check("R10 busy write dropped", cap_n - base, 0);
      check("R11 empty start no irq", irq_n, 1);

      // R9 chip select high write ignored
      wr(1'b0, 8'h55, 1'b1);
      wr(1'b1, 8'h01);
      repeat (20) @(negedge clk);
      check("R9 cs_n high ignored", cap_n - base, 0);

      // R2 fill past capacity
      for (int i = 0; i < 64; i++) wr(1'b0, 8'((i * 7 + 3) & 8'hFF));
      base = cap_n;
      wr(1'b1, 8'h01);
      repeat (16 * 63 - 1) @(negedge clk);
      check("R2 irq not early", irq_n, 1);
      @(negedge clk);
      check("R2 irq after 63 bytes", irq_n, 0);
      repeat (3) @(negedge clk);
      check("R2 bits for 63 bytes", cap_n - base, 504);
      bad = 0;
      for (int i = 0; i < 63; i++)
         if (byte_at(base, i) != ((i * 7 + 3) & 8'hFF)) bad++;
      check("R2 R5 stored bytes", bad, 0);
      wr(1'b1, 8'h06);

      // R1 reset mid transfer
      wr(1'b1, 8'h03);
      wr(1'b1, 8'h05);
      wr(1'b0, 8'h81);
      wr(1'b0, 8'h42);
      wr(1'b1, 8'h01);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid reset oe_n", oe_n, 1);
      check("R1 mid reset latch", latch, 0);
      check("R1 mid reset sclk", sclk, 0);
      check("R1 mid reset sdata", sdata, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      base = cap_n;
      wr(1'b1, 8'h01);
      repeat (20) @(negedge clk);
      check("R1 store emptied", cap_n - base, 0);
      check("R1 irq after reset", irq_n, 1);

      finish_run();
   end

endmodule